// File: doc/BRIEF.md
# BIST PRBS Payload Checker

This block sits on the receive side of a serial link. During a built-in self-test it checks the recovered parallel payload, one 24-bit word per recovered clock, against a pseudo-random sequence that it generates itself. The transmit side must already be sending the same sequence before the receiver's test enable is raised. The block locks onto the incoming stream by seeding its own sequence state from the received words. After that it compares every word.

The pass output shows one verdict per test. While a test runs, the output keeps showing the verdict of the previous test. When the enable drops, the output takes the new verdict and holds it until the next test ends. A test fails if any payload word differs from the expected word, or if the link-lock input goes low while the test runs.

A counter reports how many words held at least one mismatched bit. It can be read after the test ends. A matching word generator for the transmit side is included so the sequence can be driven into the checker.

Top module: `bist_payload_checker`

## Requirements
- R1: After reset, `pass` is 0 (fail) and `err_count` is 0.
- R2: The expected payload is the PRBS-23 sequence x^23 + x^18 + 1, advanced 24 bits per word. Each new bit is `state[22] ^ state[17]` and is shifted into `state[0]`. The first bit generated in a word lands in bit 23 and the last in bit 0. A clean stream of this sequence gives a pass verdict.
- R3: While `bist_en` is sampled high, `pass` does not change and keeps the previous verdict.
- R4: On the clock edge that samples `bist_en` low after it was sampled high, `pass` becomes 1 if the test saw no error and 0 otherwise. It then holds that value while `bist_en` stays low.
- R5: Any compared word that differs from the expected word, in any number of bits, makes the verdict a fail.
- R6: Words are numbered from 0, counting from the first word sampled with `bist_en` high. Words 0 to 2 are ignored entirely. Word 3 supplies the seed. Comparison starts at word 4.
- R7: If `lock` is sampled low on any word while `bist_en` is high, the verdict is a fail. If `lock` is low while `bist_en` is low, neither the verdict nor the count changes.
- R8: `err_count` goes up by one for each compared word that has at least one mismatched bit. It is cleared on the first word of a test and held while `bist_en` is low.
- R9: `err_count` saturates at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_en | input | 1 | Receiver self-test enable |
| lock | input | 1 | Link lock status, high when the recovered clock is valid |
| rx_word | input | 24 | Received parallel payload word |
| pass | output | 1 | Verdict of the last completed test (1 = pass) |
| err_count | output | 16 | Number of mismatched words in the last or current test |

## Verification
A wrong sequence state or a wrong tap shows up in two ways. Every compared word mismatches, so `err_count` rises on every cycle starting with word 4. The verdict at the next fall of the enable is then a fail, even though the stream was clean. A sticky error flag that is stuck high, or that is not cleared when a test starts, shows at `pass` one cycle after the enable falls. An alignment window of the wrong length shows the same way, because a corrupted early word is then either compared or used as the seed. A verdict register that follows the enable or the error flag too early shows as a change in `pass` in the middle of a test.

// File: rtl/prbs_word_gen.sv
module prbs_word_gen #(
  parameter int WORD_W = 24,
  parameter int POLY_LEN = 23,
  parameter int POLY_TAP = 18,
  parameter logic [POLY_LEN-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [WORD_W-1:0] tx_word
);

  logic [POLY_LEN-1:0] state;
  logic [POLY_LEN-1:0] st_nx;
  logic [WORD_W-1:0]   w_nx;

  always_comb begin
    logic fb;
    st_nx = state;
    w_nx  = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb      = st_nx[POLY_LEN-1] ^ st_nx[POLY_TAP-1];
      w_nx[i] = fb;
      st_nx   = {st_nx[POLY_LEN-2:0], fb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEED;
      tx_word <= '0;
    end else if (advance) begin
      state   <= st_nx;
      tx_word <= w_nx;
    end
  end

endmodule

// File: rtl/bist_payload_checker.sv
module bist_payload_checker #(
  parameter int WORD_W = 24,
  parameter int POLY_LEN = 23,
  parameter int POLY_TAP = 18,
  parameter int ALIGN_WORDS = 4,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en,
  input  logic              lock,
  input  logic [WORD_W-1:0] rx_word,
  output logic              pass,
  output logic [CNT_W-1:0]  err_count
);

  localparam int IDX_W = $clog2(ALIGN_WORDS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(ALIGN_WORDS);

  logic                en_q;
  logic [IDX_W-1:0]    idx;
  logic [POLY_LEN-1:0] ref_state;
  logic [POLY_LEN-1:0] next_state;
  logic [WORD_W-1:0]   exp_word;
  logic                err_flag;
  logic                aligned;
  logic                starting;
  logic                mismatch;

  always_comb begin
    logic fb;
    next_state = ref_state;
    exp_word   = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb          = next_state[POLY_LEN-1] ^ next_state[POLY_TAP-1];
      exp_word[i] = fb;
      next_state  = {next_state[POLY_LEN-2:0], fb};
    end
  end

  assign starting = bist_en && !en_q;
  assign aligned  = (idx == IDX_END);
  assign mismatch = bist_en && en_q && aligned && (rx_word != exp_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      idx       <= '0;
      ref_state <= '0;
    end else begin
      en_q <= bist_en;
      if (starting) begin
        idx       <= IDX_ONE;
        ref_state <= rx_word[POLY_LEN-1:0];
      end else if (bist_en) begin
        if (aligned) begin
          ref_state <= next_state;
        end else begin
          idx       <= idx + IDX_ONE;
          ref_state <= rx_word[POLY_LEN-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag  <= 1'b0;
      err_count <= '0;
      pass      <= 1'b0;
    end else if (starting) begin
      err_flag  <= !lock;
      err_count <= '0;
    end else if (bist_en) begin
      if (mismatch || !lock) err_flag <= 1'b1;
      if (mismatch && err_count != CNT_MAX) err_count <= err_count + 1'b1;
    end else if (en_q) begin
      pass <= !err_flag;
    end
  end

endmodule

// File: rtl/bist_payload_checker_sva.sv
module bist_payload_checker_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bist_en,
  input logic             lock,
  input logic             pass,
  input logic [CNT_W-1:0] err_count,
  input logic             err_flag,
  input logic             en_q
);

  a_r3_pass_held_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    bist_en |=> $stable(pass));

  a_r4_verdict_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!bist_en && en_q) |=> (pass == !$past(err_flag)));

  a_r7_lock_loss_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && !lock) |=> err_flag);

  a_r8_count_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bist_en |=> $stable(err_count));

  a_r9_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_en && en_q && (err_count == {CNT_W{1'b1}})) |=> (err_count == {CNT_W{1'b1}}));

endmodule

bind bist_payload_checker bist_payload_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .lock(lock), .pass(pass),
  .err_count(err_count), .err_flag(err_flag), .en_q(en_q)
);

// File: tb/bist_payload_checker_test.sv
module bist_payload_checker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bist_en = 1'b0;
  logic        lock = 1'b1;
  logic [23:0] err_mask = '0;
  logic [23:0] tx_word;
  logic [23:0] rx_word;
  logic        pass;
  logic [15:0] err_count;
  int          n_tests = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  assign rx_word = tx_word ^ err_mask;

  prbs_word_gen gen (.clk(clk), .rst_n(rst_n), .advance(1'b1), .tx_word(tx_word));

  bist_payload_checker uut (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .lock(lock),
    .rx_word(rx_word), .pass(pass), .err_count(err_count)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_test(input int len, input int e_lo, input int e_hi, input logic [23:0] mask,
                          input int l_lo, input int l_hi, input logic prev,
                          input logic exp_pass, input int exp_cnt, input string tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      bist_en  = 1'b1;
      err_mask = (i >= e_lo && i < e_hi) ? mask : 24'h0;
      lock     = !(i >= l_lo && i < l_hi);
      if (i == len / 2) check({"R3 pass held during ", tag}, int'(pass), int'(prev));
    end
    @(negedge clk);
    bist_en  = 1'b0;
    err_mask = '0;
    lock     = 1'b1;
    @(negedge clk);
    check({"R4 verdict ", tag}, int'(pass), int'(exp_pass));
    check({"R8 count ", tag}, int'(err_count), exp_cnt);
  endtask

  task automatic t_reset();
    check("R1 pass after reset", int'(pass), 0);
    check("R1 count after reset", int'(err_count), 0);
  endtask

  task automatic t_clean();
    run_test(40, -1, -1, 24'h0, -1, -1, 1'b0, 1'b1, 0, "R2 clean stream");
  endtask

  task automatic t_bit_errors();
    run_test(40, 10, 13, 24'h800001, -1, -1, 1'b1, 1'b0, 3, "R5 three bad words");
    repeat (5) @(negedge clk);
    check("R8 count held while idle", int'(err_count), 3);
    check("R4 verdict held while idle", int'(pass), 0);
  endtask

  task automatic t_align_ignore();
    run_test(30, 0, 3, 24'hFFFFFF, -1, -1, 1'b0, 1'b1, 0, "R6 early words ignored");
  endtask

  task automatic t_single_word_all_bits();
    run_test(30, 4, 5, 24'hFFFFFF, -1, -1, 1'b1, 1'b0, 1, "R5 first compared word");
  endtask

  task automatic t_lock_drop();
    run_test(30, -1, -1, 24'h0, -1, -1, 1'b0, 1'b1, 0, "R2 clean before lock test");
    run_test(30, -1, -1, 24'h0, 20, 21, 1'b1, 1'b0, 0, "R7 lock lost mid test");
  endtask

  task automatic t_lock_idle();
    run_test(30, -1, -1, 24'h0, -1, -1, 1'b0, 1'b1, 0, "R7 clean before idle lock loss");
    @(negedge clk);
    lock = 1'b0;
    repeat (5) @(negedge clk);
    lock = 1'b1;
    check("R7 idle lock loss keeps verdict", int'(pass), 1);
    check("R7 idle lock loss keeps count", int'(err_count), 0);
    run_test(30, -1, -1, 24'h0, -1, -1, 1'b1, 1'b1, 0, "R7 clean after idle lock loss");
  endtask

  task automatic t_saturate();
    run_test(65550, 4, 65550, 24'h000100, -1, -1, 1'b1, 1'b0, 65535, "R9 saturation");
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    t_reset();
    t_clean();
    t_bit_errors();
    t_align_ignore();
    t_single_word_all_bits();
    t_lock_drop();
    t_lock_idle();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule